// File: doc/BRIEF.md
# Quasi-Bidirectional Microcontroller Port

This block is one general-purpose I/O port of a small 8-bit microcontroller, one output latch per pin. A write strobe loads the port latches from the internal data bus. Two separate read strobes return either the latch contents or the levels seen on the pins. The pad itself is outside the block. The block produces three enables per pin: an active pull-down, an active pull-up, and a weak pullup. It receives the resolved pin level back on `pin_in`.

A compile-time parameter picks one of four port flavours:
- a true bidirectional port whose driver can be taken over by a multiplexed address/data value;
- a plain quasi-bidirectional port;
- a quasi-bidirectional port whose driver can be taken over by a high address byte;
- a quasi-bidirectional port whose output is combined with alternate output functions and which reports pin levels to alternate input functions.

To use a pin as an input, software writes 1 to its latch and then reads the pin.

Top module: `qb_port`

## Requirements
- R1: On a rising clock edge with `wr_stb` high, every latch bit takes the value of `bus_wr_data`. Without `wr_stb` the latches hold their value.
- R2: When `rd_latch_stb` is high at a clock edge, `rd_data` shows the latch contents from before that edge on the next cycle. A write in the same cycle is not seen. `rd_latch_stb` wins over `rd_pin_stb`.
- R3: When only `rd_pin_stb` is high at a clock edge, `rd_data` shows `pin_in` as sampled at that edge. With no read strobe, `rd_data` holds its value.
- R4: A latch bit of 0 turns that pin's pull-down on (`drv_low`=1, `drv_high`=0, `pull_en`=0). This applies unless the pin is taken over by the bus mux (R7) or the alternate function (R8).
- R5: On the quasi-bidirectional flavours (FLAVOR 1 and 2), a latch bit of 1 gives `pull_en`=1 and `drv_low`=0.
- R6: On the true bidirectional flavour (FLAVOR 0), a latch bit of 1 turns all three enables off, so the pin floats.
- R7: On flavours 0 and 2, while `mux_sel` is 1, each pin drives `mux_val` actively: `drv_high`=`mux_val`, `drv_low`=~`mux_val`, `pull_en`=0. The latches keep their contents during this time. On flavours 1 and 3, `mux_sel` has no effect.
- R8: On the alternate-function flavour (FLAVOR 3), the level driven is latch AND `alt_out`: a 0 enables the pull-down and a 1 enables the weak pullup.
- R9: On FLAVOR 3, `alt_in` equals `pin_in` at all times, whatever the latches hold. On the other flavours, `alt_in` is 0.
- R10: A clock edge with `rst_n` low sets every latch to 1 and clears `rd_data`.
- R11: `drv_low` and `drv_high` are never both 1 on the same pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_data | input | W | Internal data bus value to be written |
| wr_stb | input | 1 | Write-to-latch strobe |
| rd_latch_stb | input | 1 | Read-latch request |
| rd_pin_stb | input | 1 | Read-pin request |
| mux_sel | input | 1 | Hands the drivers to the address/data value (flavours 0, 2) |
| mux_val | input | W | Address or address/data value to drive |
| alt_out | input | W | Alternate output function levels (flavour 3) |
| pin_in | input | W | Resolved pin levels from the pad |
| drv_low | output | W | Strong pull-down enable per pin |
| drv_high | output | W | Strong pull-up enable per pin |
| pull_en | output | W | Weak pullup enable per pin |
| rd_data | output | W | Registered read result |
| alt_in | output | W | Pin levels for alternate input functions (flavour 3) |

## Verification
A wrong latch bit appears on the driver enables in the same cycle it is loaded. It also appears on `rd_data` one cycle after a read-latch request. The bench therefore compares every enable of every pin on every clock, for all four flavours side by side. Read-path errors, such as the wrong source or a same-cycle write leaking into the read, appear one cycle after the strobe. External pull-low patterns are applied so that a pin read which wrongly returns the latch value differs from the expected pin level. Directed steps cover reset, writes while the mux is active, and a read issued in the same cycle as a write. A long random phase follows.

// File: rtl/qb_port_pkg.sv
// Package: shared types for the port block.
// Assumes: flavour codes are fixed; the driver and readback logic select on them.
package qb_port_pkg;
    typedef enum logic [1:0] {
        FLV_TRUE_BIDIR = 2'd0,
        FLV_QUASI      = 2'd1,
        FLV_QUASI_HI   = 2'd2,
        FLV_QUASI_ALT  = 2'd3
    } port_flavor_e;

    // True when the flavour lets the address/data mux take the drivers.
    function automatic logic flavor_has_mux(port_flavor_e f);
        return (f == FLV_TRUE_BIDIR) || (f == FLV_QUASI_HI);
    endfunction
endpackage

// File: rtl/qb_port_latch.sv
// Module: bank of D-type port latches.
// Does: loads every bit from the bus on a write strobe; reset sets all to 1.
// Assumes: synchronous active-low reset.
module qb_port_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Latch update: reset to all ones, else load on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '1;
        else if (wr_stb) q <= d;
    end
endmodule

// File: rtl/qb_port_driver.sv
// Module: per-pin driver enable selection.
// Does: turns latch, mux and alternate inputs into pull-down, pull-up and
//       weak-pullup enables, according to the FLAVOR parameter.
// Assumes: purely combinational; the pad resolves the level outside.
module qb_port_driver
    import qb_port_pkg::*;
#(
    parameter int           W      = 8,
    parameter port_flavor_e FLAVOR = FLV_QUASI
) (
    input  logic [W-1:0] q,
    input  logic         mux_sel,
    input  logic [W-1:0] mux_val,
    input  logic [W-1:0] alt_out,
    output logic [W-1:0] drv_low,
    output logic [W-1:0] drv_high,
    output logic [W-1:0] pull_en
);
    localparam bit HAS_MUX = flavor_has_mux(FLAVOR);

    generate
        if (FLAVOR == FLV_TRUE_BIDIR) begin : g_bidir
            // Open drain from the latch, push-pull while the bus mux drives.
            always_comb begin
                if (mux_sel) begin
                    drv_low  = ~mux_val;
                    drv_high = mux_val;
                end else begin
                    drv_low  = ~q;
                    drv_high = '0;
                end
                pull_en = '0;
            end
        end else if (FLAVOR == FLV_QUASI_ALT) begin : g_alt
            logic [W-1:0] level;
            // Latch gates the alternate output; weak pullup carries the ones.
            always_comb begin
                level    = q & alt_out;
                drv_low  = ~level;
                drv_high = '0;
                pull_en  = level;
            end
        end else if (HAS_MUX) begin : g_hi
            // Quasi-bidirectional, with the high address byte taking over when muxed.
            always_comb begin
                if (mux_sel) begin
                    drv_low  = ~mux_val;
                    drv_high = mux_val;
                    pull_en  = '0;
                end else begin
                    drv_low  = ~q;
                    drv_high = '0;
                    pull_en  = q;
                end
            end
        end else begin : g_quasi
            // Plain quasi-bidirectional: pull-down for 0, weak pullup for 1.
            always_comb begin
                drv_low  = ~q;
                drv_high = '0;
                pull_en  = q;
            end
        end
    endgenerate
endmodule

// File: rtl/qb_port_readback.sv
// Module: read path and alternate-input tap.
// Does: registers either the latch or the pin levels on a read request
//       (latch wins); passes pin levels to alternate inputs on flavour 3.
// Assumes: q is sampled before the same-edge write lands.
module qb_port_readback
    import qb_port_pkg::*;
#(
    parameter int           W      = 8,
    parameter port_flavor_e FLAVOR = FLV_QUASI
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_latch_stb,
    input  logic         rd_pin_stb,
    input  logic [W-1:0] q,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] alt_in
);
    // Read register: capture the selected source on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)            rd_data <= '0;
        else if (rd_latch_stb) rd_data <= q;
        else if (rd_pin_stb)   rd_data <= pin_in;
    end

    generate
        if (FLAVOR == FLV_QUASI_ALT) begin : g_alt_tap
            // Alternate input always sees the real pin.
            always_comb alt_in = pin_in;
        end else begin : g_no_tap
            // No alternate input on this flavour.
            always_comb alt_in = '0;
        end
    endgenerate
endmodule

// File: rtl/qb_port.sv
// Module: top of one microcontroller I/O port.
// Does: joins the latch bank, driver selection and read path.
// Assumes: the pad outside resolves the pin and returns it on pin_in.
module qb_port
    import qb_port_pkg::*;
#(
    parameter int           W      = 8,
    parameter port_flavor_e FLAVOR = FLV_QUASI_ALT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_wr_data,
    input  logic         wr_stb,
    input  logic         rd_latch_stb,
    input  logic         rd_pin_stb,
    input  logic         mux_sel,
    input  logic [W-1:0] mux_val,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] drv_low,
    output logic [W-1:0] drv_high,
    output logic [W-1:0] pull_en,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] alt_in
);
    logic [W-1:0] q_lat;

    qb_port_latch #(.W(W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .d      (bus_wr_data),
        .q      (q_lat)
    );

    qb_port_driver #(.W(W), .FLAVOR(FLAVOR)) u_drv (
        .q        (q_lat),
        .mux_sel  (mux_sel),
        .mux_val  (mux_val),
        .alt_out  (alt_out),
        .drv_low  (drv_low),
        .drv_high (drv_high),
        .pull_en  (pull_en)
    );

    qb_port_readback #(.W(W), .FLAVOR(FLAVOR)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_latch_stb (rd_latch_stb),
        .rd_pin_stb   (rd_pin_stb),
        .q            (q_lat),
        .pin_in       (pin_in),
        .rd_data      (rd_data),
        .alt_in       (alt_in)
    );
endmodule

// File: rtl/qb_port_chk.sv
// Module: assertion checker for qb_port, attached by bind below.
// Assumes: it observes the internal latch through the bind connection.
module qb_port_chk
    import qb_port_pkg::*;
#(
    parameter int           W      = 8,
    parameter port_flavor_e FLAVOR = FLV_QUASI_ALT
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] bus_wr_data,
    input logic         wr_stb,
    input logic         rd_latch_stb,
    input logic         rd_pin_stb,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] q_lat,
    input logic [W-1:0] drv_low,
    input logic [W-1:0] drv_high,
    input logic [W-1:0] pull_en,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] alt_in
);
    p_latch_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> q_lat == $past(bus_wr_data));

    p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(q_lat));

    p_read_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_latch_stb |=> rd_data == $past(q_lat));

    p_read_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pin_stb && !rd_latch_stb) |=> rd_data === $past(pin_in));

    p_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_pin_stb && !rd_latch_stb) |=> $stable(rd_data));

    p_no_contention_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_low & drv_high) == '0);

    p_pull_vs_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_en & drv_low) == '0);

    generate
        if (FLAVOR == FLV_QUASI_ALT) begin : g_alt_chk
            p_alt_follows_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
                alt_in === pin_in);
        end else begin : g_noalt_chk
            p_alt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
                alt_in == '0);
        end
    endgenerate
endmodule

bind qb_port qb_port_chk #(.W(W), .FLAVOR(FLAVOR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_data  (bus_wr_data),
    .wr_stb       (wr_stb),
    .rd_latch_stb (rd_latch_stb),
    .rd_pin_stb   (rd_pin_stb),
    .pin_in       (pin_in),
    .q_lat        (q_lat),
    .drv_low      (drv_low),
    .drv_high     (drv_high),
    .pull_en      (pull_en),
    .rd_data      (rd_data),
    .alt_in       (alt_in)
);

// File: tb/qb_port_test.sv
module qb_port_test;
    import qb_port_pkg::*;
    localparam int W = 8;
    localparam int NF = 4;

    logic clk = 0;
    always #4 clk = ~clk;   // 125 MHz

    logic         rst_n = 0;
    logic [W-1:0] bus_wr_data = '0, mux_val = '0, alt_out = '0, ext_low = '0;
    logic         wr_stb = 0, rd_latch_stb = 0, rd_pin_stb = 0, mux_sel = 0;

    logic [W-1:0] dl [NF], dh [NF], pu [NF], rd [NF], ai [NF], pin [NF];

    int tests = 0, fails = 0;
    bit done = 0;

    // Pad model: wired-AND of the internal drive and the external pull-low.
    function automatic logic [W-1:0] resolve(int f, logic [W-1:0] l, logic [W-1:0] h,
                                             logic [W-1:0] p, logic [W-1:0] ext);
        logic [W-1:0] r;
        for (int b = 0; b < W; b++) begin
            if (l[b] || ext[b])  r[b] = 1'b0;
            else if (h[b] || p[b]) r[b] = 1'b1;
            else if (f == 0)     r[b] = 1'bx;
            else                 r[b] = 1'b1;
        end
        return r;
    endfunction

    for (genvar f = 0; f < NF; f++) begin : g_dut
        assign pin[f] = resolve(f, dl[f], dh[f], pu[f], ext_low);
        qb_port #(.W(W), .FLAVOR(port_flavor_e'(f))) uut (
            .clk(clk), .rst_n(rst_n), .bus_wr_data(bus_wr_data), .wr_stb(wr_stb),
            .rd_latch_stb(rd_latch_stb), .rd_pin_stb(rd_pin_stb), .mux_sel(mux_sel),
            .mux_val(mux_val), .alt_out(alt_out), .pin_in(pin[f]),
            .drv_low(dl[f]), .drv_high(dh[f]), .pull_en(pu[f]), .rd_data(rd[f]), .alt_in(ai[f]));
    end

    // Reference model state.
    logic [W-1:0] m_lat = '1;
    logic [W-1:0] m_rd [NF];
    string        rd_tag = "R10";
    bit           model_live = 0;

    initial for (int f = 0; f < NF; f++) m_rd[f] = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat <= '1;
            for (int f = 0; f < NF; f++) m_rd[f] <= '0;
            rd_tag <= "R10";
            model_live <= 1;
        end else begin
            for (int f = 0; f < NF; f++) begin
                if (rd_latch_stb)    m_rd[f] <= m_lat;
                else if (rd_pin_stb) m_rd[f] <= pin[f];
            end
            if (rd_latch_stb)    rd_tag <= "R2";
            else if (rd_pin_stb) rd_tag <= "R3";
            if (wr_stb) m_lat <= bus_wr_data;
        end
    end

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp, string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Compare every output of every flavour against the model, each clock.
    always @(negedge clk) begin
        if (model_live && rst_n && !done) begin
            for (int f = 0; f < NF; f++) begin
                for (int b = 0; b < W; b++) begin
                    logic lv, el, eh, ep;
                    string tg;
                    if ((f == 0 || f == 2) && mux_sel) begin
                        el = ~mux_val[b]; eh = mux_val[b]; ep = 0; tg = "R7";
                    end else if (f == 3) begin
                        lv = m_lat[b] & alt_out[b];
                        el = ~lv; eh = 0; ep = lv; tg = "R8";
                    end else if (!m_lat[b]) begin
                        el = 1; eh = 0; ep = 0; tg = "R4";
                    end else if (f == 0) begin
                        el = 0; eh = 0; ep = 0; tg = "R6";
                    end else begin
                        el = 0; eh = 0; ep = 1; tg = "R5";
                    end
                    check(tg, {5'd0, dl[f][b], dh[f][b], pu[f][b]}, {5'd0, el, eh, ep},
                          $sformatf("flv%0d bit%0d {low,high,pull}", f, b));
                end
                check("R11", dl[f] & dh[f], '0, $sformatf("flv%0d contention", f));
                check(rd_tag, rd[f], m_rd[f], $sformatf("flv%0d rd_data", f));
                check("R9", ai[f], (f == 3) ? pin[f] : '0, $sformatf("flv%0d alt_in", f));
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        wr_stb = 0; rd_latch_stb = 0; rd_pin_stb = 0;
    endtask

    initial begin
        step(); step(); step();
        rst_n = 1;
        // R10: latches read back as all ones after reset.
        rd_latch_stb = 1; step(); idle();
        @(negedge clk);
        for (int f = 0; f < NF; f++) check("R10", rd[f], 8'hFF, "latch after reset");
        step();
        // R1: write then read back.
        bus_wr_data = 8'hA5; wr_stb = 1; step(); idle();
        rd_latch_stb = 1; step(); idle();
        @(negedge clk);
        check("R1", rd[1], 8'hA5, "latch after write");
        step();
        // R2: read and write on the same cycle return the old value.
        bus_wr_data = 8'h3C; wr_stb = 1; rd_latch_stb = 1; step(); idle();
        @(negedge clk);
        check("R2", rd[2], 8'hA5, "read with same-cycle write");
        step();
        // R3: pin read with external pull-lows on input pins.
        bus_wr_data = 8'hF0; wr_stb = 1; step(); idle();
        ext_low = 8'h50; rd_pin_stb = 1; step(); idle();
        @(negedge clk);
        check("R3", rd[1], 8'hA0, "pin read quasi");
        step();
        // R8: alternate output patterns.
        alt_out = 8'hCC; step(); alt_out = 8'h33; step(); ext_low = '0; step();
        // R7: mux drives, latch written meanwhile and retained.
        mux_sel = 1; mux_val = 8'h96; step();
        bus_wr_data = 8'h0F; wr_stb = 1; step(); idle();
        mux_val = 8'h69; step();
        mux_sel = 0; rd_latch_stb = 1; step(); idle();
        @(negedge clk);
        check("R7", rd[0], 8'h0F, "latch kept through mux");
        step();
        // Random phase.
        for (int i = 0; i < 400; i++) begin
            bus_wr_data = W'($urandom); mux_val = W'($urandom); alt_out = W'($urandom);
            ext_low = W'($urandom) & W'($urandom);
            wr_stb = 1'($urandom); rd_latch_stb = ($urandom % 3) == 0;
            rd_pin_stb = 1'($urandom); mux_sel = ($urandom % 4) == 0;
            if (i == 200) rst_n = 0;
            if (i == 202) rst_n = 1;
            step();
        end
        idle(); step();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule